// File: doc/BRIEF.md
# Sampling Converter Conversion Control and Parallel Output Interface

This block holds the digital control and output side of a 14-bit sampling converter. A host requests a conversion by pulling the conversion-start strobe low while chip select is asserted (low). The block raises no new request while one is running, drives an active-high ready flag (`busy_o` is low while converting), and stores each finished result in an output register. The previous result therefore stays readable while a new conversion runs. In place of the analog core, a latency counter is used. It latches a 14-bit sample from a port when a conversion starts and delivers that sample as the result a fixed number of clocks later.

All control strobes are asynchronous to the system clock. They pass through a synchronizer before edge detection and decoding. The stored result goes out on a 14-bit parallel bus with one output-enable line, and the pad ring turns that line into a three-state driver. The enable is asserted only when chip select and read are both low and parallel mode is selected. With serial mode selected, the bus stays in high impedance. A coding input chooses the result format: straight binary, or two's complement made by inverting the MSB of the core result.

Top module: `adc_ctrl_if`

## Requirements
- R1: After reset, `busy_o` is 1, `data_oe_o` is 0, and the stored result is zero, so a first read in straight-binary coding returns 0.
- R2: A conversion starts when a falling edge of `convst_ni` is seen while `cs_ni` is low. `busy_o` falls on the (SYNC_STAGES+1)-th rising clock edge after the strobe falls.
- R3: A falling edge of `convst_ni` while `cs_ni` is high starts nothing. `busy_o` stays 1 and the stored result is unchanged.
- R4: Falling edges of `convst_ni` while a conversion runs are ignored. The conversion length and result are unaffected, and no further conversion follows.
- R5: `busy_o` stays low for exactly LATENCY clock cycles per conversion.
- R6: The stored result changes only when a conversion ends. Throughout a conversion the prior result is still read out.
- R7: `data_oe_o` is 1 only when the synchronized `cs_ni`, `rd_ni` and `ser_sel_i` are all 0. `data_o` is 0 whenever `data_oe_o` is 0.
- R8: With `ser_sel_i` high, `data_oe_o` stays 0 whatever `cs_ni` and `rd_ni` are.
- R9: With `bipolar_i` = 0, `data_o` equals the converted sample (straight binary). With `bipolar_i` = 1, `data_o` is the sample with bit 13 inverted (two's complement).
- R10: The sample is latched on the cycle the conversion starts. Later changes to `sample_i` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| convst_ni | input | 1 | Conversion-start strobe; a falling edge requests a conversion |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| ser_sel_i | input | 1 | 1 selects serial mode (parallel bus held in high impedance) |
| bipolar_i | input | 1 | 1 selects two's complement coding, 0 straight binary |
| sample_i | input | 14 | Sample value taken in by the core model at conversion start |
| busy_o | output | 1 | Low while a conversion is in progress |
| data_o | output | 14 | Parallel result, zero when not enabled |
| data_oe_o | output | 1 | Output enable for the parallel pad drivers |

## Verification
The hardest case to reach is a second start strobe that arrives in the middle of a running conversion. The design must drop it, and it must not hold it as a pending request that fires once `busy_o` rises. Every conversion in the sweep produces this case: partway through the busy window the bench releases and then re-asserts the strobe. It then checks the busy length, the result, and that `busy_o` stays high for several cycles afterwards. A new sample is also driven on `sample_i` right after the start, which shows that the result comes from the value latched at the start.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned DEF_WIDTH   = 14;
  localparam int unsigned DEF_LATENCY = 16;
  localparam int unsigned DEF_SYNC    = 2;

  typedef enum logic {
    CODE_STRAIGHT = 1'b0,
    CODE_TWOS     = 1'b1
  } coding_e;

  // bit positions inside the synchronized control vector
  localparam int unsigned CTL_CS     = 0;
  localparam int unsigned CTL_CONVST = 1;
  localparam int unsigned CTL_RD     = 2;
  localparam int unsigned CTL_SER    = 3;
  localparam int unsigned CTL_N      = 4;
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_conv_core.sv
module adc_conv_core #(
  parameter int unsigned W       = 14,
  parameter int unsigned LATENCY = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] sample_i,
  output logic         active_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      smp_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_LOAD;
        smp_q    <= sample_i;
      end
    end else if (cnt_q == '0) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign done_o   = active_q && (cnt_q == '0);
  assign result_o = smp_q;
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic [W-1:0] result_i,
  input  coding_e      coding_i,
  input  logic         oe_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] res_q;
  logic [W-1:0] coded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (done_i) res_q <= result_i;
  end

  // offset binary to two's complement: flip the sign bit
  always_comb begin
    coded = res_q;
    if (coding_i == CODE_TWOS) coded[W-1] = ~res_q[W-1];
  end

  assign data_o = oe_i ? coded : '0;
endmodule

// File: rtl/adc_ctrl_if.sv
module adc_ctrl_if
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned LATENCY     = DEF_LATENCY,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             convst_ni,
  input  logic             rd_ni,
  input  logic             ser_sel_i,
  input  logic             bipolar_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o
);
  localparam logic [CTL_N-1:0] CTL_IDLE = CTL_N'(4'b0111);

  logic [CTL_N-1:0] ctl_raw, ctl_s;
  logic             convst_prev_q;
  logic             convst_fall;
  logic             start;
  logic             active, done;
  logic [WIDTH-1:0] core_res;
  logic             oe;

  always_comb begin
    ctl_raw             = '0;
    ctl_raw[CTL_CS]     = cs_ni;
    ctl_raw[CTL_CONVST] = convst_ni;
    ctl_raw[CTL_RD]     = rd_ni;
    ctl_raw[CTL_SER]    = ser_sel_i;
  end

  adc_in_sync #(
    .N      (CTL_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) convst_prev_q <= 1'b1;
    else         convst_prev_q <= ctl_s[CTL_CONVST];
  end

  assign convst_fall = convst_prev_q && !ctl_s[CTL_CONVST];
  assign start       = convst_fall && !ctl_s[CTL_CS] && !active;

  adc_conv_core #(
    .W      (WIDTH),
    .LATENCY(LATENCY)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .sample_i(sample_i),
    .active_o(active),
    .done_o  (done),
    .result_o(core_res)
  );

  assign oe = !ctl_s[CTL_CS] && !ctl_s[CTL_RD] && !ctl_s[CTL_SER];

  adc_out_stage #(
    .W(WIDTH)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .result_i(core_res),
    .coding_i(bipolar_i ? CODE_TWOS : CODE_STRAIGHT),
    .oe_i    (oe),
    .data_o  (data_o)
  );

  assign busy_o    = !active;
  assign data_oe_o = oe;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int unsigned WIDTH       = 14,
  parameter int unsigned LATENCY     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             rd_ni,
  input logic             ser_sel_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] data_o,
  input logic             data_oe_o,
  input logic [WIDTH-1:0] res_i
);
  logic [31:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt_q <= '0;
    else if (!busy_o) low_cnt_q <= low_cnt_q + 1;
    else              low_cnt_q <= '0;
  end

  AST_START_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(cs_ni, SYNC_STAGES + 1)); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (low_cnt_q == LATENCY)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(res_i)); // R6

  AST_BUS_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R7

  AST_OE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ($past(!cs_ni, SYNC_STAGES) && $past(!rd_ni, SYNC_STAGES))); // R7

  AST_SERIAL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ser_sel_i, SYNC_STAGES) |-> !data_oe_o); // R8
endmodule

bind adc_ctrl_if adc_ctrl_chk #(
  .WIDTH      (WIDTH),
  .LATENCY    (LATENCY),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .rd_ni    (rd_ni),
  .ser_sel_i(ser_sel_i),
  .busy_o   (busy_o),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .res_i    (u_out.res_q)
);

// File: tb/tb_adc_ctrl_if.sv
module tb_adc_ctrl_if;
  localparam int W    = 14;
  localparam int LAT  = 16;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, convst_n, rd_n, ser, bip;
  logic [W-1:0] sample;
  logic         busy, oe;
  logic [W-1:0] data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_res;

  always #2 clk = ~clk;

  adc_ctrl_if #(.WIDTH(W), .LATENCY(LAT), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .convst_ni(convst_n),
    .rd_ni(rd_n), .ser_sel_i(ser), .bipolar_i(bip), .sample_i(sample),
    .busy_o(busy), .data_o(data), .data_oe_o(oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] code(input logic [W-1:0] v, input logic b);
    return b ? (v ^ (14'h1 << (W - 1))) : v;
  endfunction

  // one conversion with cs/rd held low, retrigger attempt in the middle
  task automatic convert(input logic [W-1:0] smp);
    int low;
    sample   = smp;
    convst_n = 1'b0;
    tick(SYNC);
    check("R2 busy still high before sync", busy, 1'b1);
    tick(1);
    check("R2 busy low after sync+1", busy, 1'b0);
    sample = ~smp;                       // R10: must not be used
    check("R6 prior result during busy", data, code(prev_res, bip));
    low = 1;
    while (busy == 1'b0 && low < 100) begin
      if (low == 2) convst_n = 1'b1;
      if (low == 5) convst_n = 1'b0;     // R4 retrigger attempt
      if (low == 9) convst_n = 1'b1;
      if (low == 8) check("R6 prior result mid conversion", data, code(prev_res, bip));
      tick(1);
      if (busy == 1'b0) low++;
    end
    check("R5 busy low length", low, LAT);
    check("R10 latched sample result", data, code(smp, bip));
    tick(6);
    check("R4 no conversion after retrigger", busy, 1'b1);
    bip = ~bip;
    tick(1);
    check("R9 other coding", data, code(smp, bip));
    bip = ~bip;
    prev_res = smp;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; convst_n = 1'b1; rd_n = 1'b1;
    ser = 1'b0; bip = 1'b0; sample = '0; prev_res = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 busy after reset", busy, 1'b1);
    check("R1 oe after reset", oe, 1'b0);
    cs_n = 1'b0; rd_n = 1'b0;
    tick(SYNC - 1);
    check("R7 oe not yet through sync", oe, 1'b0);
    tick(1);
    check("R7 oe asserted", oe, 1'b1);
    check("R1 zero result", data, '0);

    // R9 corner samples in both codings
    convert(14'h0000);
    convert(14'h3FFF);
    convert(14'h2000);
    bip = 1'b1;
    convert(14'h1FFF);
    convert(14'h0001);
    bip = 1'b0;
    for (int i = 0; i < 40; i++) begin
      bip = i[0];
      convert(14'((i * 1231 + 77) % 16384));
    end
    bip = 1'b0;

    // R3 start while deselected
    cs_n = 1'b1; tick(SYNC + 1);
    sample = 14'h1234;
    convst_n = 1'b0;
    for (int k = 0; k < LAT; k++) begin
      tick(1);
      if (k == SYNC + 2 || k == LAT - 1) check("R3 busy stays high deselected", busy, 1'b1);
    end
    convst_n = 1'b1;
    tick(2);
    cs_n = 1'b0; tick(SYNC + 1);
    check("R3 result unchanged", data, prev_res);
    check("R3 busy high", busy, 1'b1);

    // R7 enable combinations
    rd_n = 1'b1; tick(SYNC + 1);
    check("R7 rd high oe", oe, 1'b0);
    check("R7 rd high data zero", data, '0);
    rd_n = 1'b0; cs_n = 1'b1; tick(SYNC + 1);
    check("R7 cs high oe", oe, 1'b0);
    cs_n = 1'b0; tick(SYNC + 1);
    check("R7 both low oe", oe, 1'b1);

    // R8 serial mode
    ser = 1'b1; tick(SYNC + 1);
    check("R8 serial oe", oe, 1'b0);
    check("R8 serial data zero", data, '0);
    ser = 1'b0; tick(SYNC + 1);
    check("R8 parallel restored", oe, 1'b1);
    check("R9 straight readback", data, prev_res);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule